// File: doc/BRIEF.md
# Dual Gated Two-to-Four Decoder

This block holds two 2-to-4 decoder sections that share one 2-bit address. Each section has its own two-input enable gate and four active-low outputs, and at most one of those outputs is low at a time. Section A is enabled by one active-high and one active-low input, so a data stream fed into either enable is steered to the addressed output either as it is or inverted. Section B is enabled by two active-low inputs.

A mode input chooses how the pair is used. In dual mode the sections work on their own. In wide mode the block connects the enables internally so the pair forms one 3-to-8 decoder. Section A's active-high enable is the third address bit, and section A's active-low enable is the shared enable. In wired mode a caller-supplied mask picks outputs from the combined 8-bit bus, and a single result line gives the AND of the picked active-low outputs, as a pulled-up open-drain line would. The block is purely combinational.

Top module: `dual_gated_decoder`

## Requirements
- R1: The address index is `addr[1]*2 + addr[0]`. Both sections decode this same index, and an enabled section drives low only the output whose index equals it.
- R2: Section A is enabled only when `a_en_hi`=1 and `a_en_lo_n`=0. When it is enabled, `a_out_n[index]` is 0 and the other three bits are 1.
- R3: When section A is not enabled, `a_out_n` is 4'b1111 for every address.
- R4: Outside wide mode, section B is enabled only when `b_en_lo_n0`=0 and `b_en_lo_n1`=0. When it is enabled, `b_out_n[index]` is 0 and the others are 1. Otherwise `b_out_n` is 4'b1111.
- R5: Demultiplexing. With `a_en_lo_n`=0, `a_out_n[index]` equals the inverse of `a_en_hi`. With `a_en_hi`=1, `a_out_n[index]` equals `a_en_lo_n`.
- R6: Mode encoding: 2'b00 is dual, 2'b01 is wide, 2'b10 is wired, and 2'b11 behaves exactly as dual.
- R7: In wide mode, the third address bit is `a_en_hi` and the shared active-low enable is `a_en_lo_n`. When `a_en_lo_n`=0, `wide_out_n[{a_en_hi,addr}]` is the single low bit; when `a_en_lo_n`=1, all eight bits are 1. `b_en_lo_n0` and `b_en_lo_n1` have no effect in this mode.
- R8: In every mode, `wide_out_n[7:4]` equals `a_out_n` and `wide_out_n[3:0]` equals `b_out_n`. In wide mode, indices 0 to 3 come from section B and indices 4 to 7 from section A.
- R9: In wired mode, `wired_and` is the AND of every `wide_out_n[i]` whose `mask[i]`=1. It is 0 if any selected output is low. In the other modes `wired_and` is 1.
- R10: In wired mode with `mask`=8'h00, `wired_and` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 2 | Shared address, bit 0 least significant |
| a_en_hi | input | 1 | Section A active-high enable; third address bit in wide mode |
| a_en_lo_n | input | 1 | Section A active-low enable; shared enable in wide mode |
| b_en_lo_n0 | input | 1 | Section B first active-low enable |
| b_en_lo_n1 | input | 1 | Section B second active-low enable |
| mode | input | 2 | 00 dual, 01 wide, 10 wired, 11 dual |
| mask | input | 8 | Output selection for the wired-AND result |
| a_out_n | output | 4 | Section A active-low outputs |
| b_out_n | output | 4 | Section B active-low outputs |
| wide_out_n | output | 8 | Combined bus, A in the upper half |
| wired_and | output | 1 | AND of the masked active-low outputs |

## Verification
The block has no stored state, so a fault in an internal enable gate or strap shows at the ports in the same evaluation as the input change that exposes it. For each mode the bench drives every combination of address and the four enables. A swapped gate polarity, a wrong strap, or a misplaced half of the wide bus therefore appears as a wrong or extra low output in the first input pattern that exercises it. The wired result is compared across several masks, including the empty mask and the full mask.

// File: rtl/dec_pkg.sv
// Package: shared definitions for the dual gated decoder.
// Assumes a 2-bit mode encoding; the unused code maps to dual operation.
package dec_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL  = 2'b00,
        MODE_WIDE  = 2'b01,
        MODE_WIRED = 2'b10,
        MODE_SPARE = 2'b11
    } dec_mode_e;

    localparam int NUM_SECTIONS = 2;

endpackage

// File: rtl/dec_enable_gate.sv
// Module: two-input enable gate for one decoder section.
// Input e1 is always active low. Parameter FIRST_ACT_HIGH sets the polarity of e0.
// Assumes single-bit inputs; the output is purely combinational.
module dec_enable_gate #(
    parameter bit FIRST_ACT_HIGH = 1'b0
) (
    input  logic e0,
    input  logic e1,
    output logic en
);

    logic e0_active;

    // Choose the polarity of the first input at elaboration time.
    generate
        if (FIRST_ACT_HIGH) begin : g_hi
            assign e0_active = e0;
        end else begin : g_lo
            assign e0_active = ~e0;
        end
    endgenerate

    // The gate opens only when both inputs are at their active levels.
    always_comb begin
        en = e0_active & ~e1;
    end

endmodule

// File: rtl/dec_section.sv
// Module: one binary decoder section with active-low, mutually exclusive outputs.
// Assumes the enable comes from a separate gate; when disabled, all outputs are high.
module dec_section #(
    parameter int ADDR_W = 2,
    localparam int OUTS  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [OUTS-1:0]   out_n
);

    // Drive the addressed output low when the section is enabled.
    always_comb begin
        out_n = '1;
        if (en) begin
            out_n[addr] = 1'b0;
        end
    end

endmodule

// File: rtl/dec_wired_and.sv
// Module: models open-drain outputs tied to one pulled-up line.
// Unselected inputs float high. The result is 1 when inactive or when nothing is selected.
module dec_wired_and #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_n,
    input  logic [W-1:0] sel,
    input  logic         active,
    output logic         y
);

    // A selected low output pulls the shared line low.
    always_comb begin
        y = 1'b1;
        if (active) begin
            y = &(in_n | ~sel);
        end
    end

endmodule

// File: rtl/dual_gated_decoder.sv
// Module: two gated 2-to-4 decoders with a shared address.
// Supports dual, 3-to-8 (wide) and masked wired-AND modes.
// Assumes a combinational context with no clock or reset. Section index 1 is A (upper half of the wide bus), index 0 is B.
module dual_gated_decoder
    import dec_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int SEC_OUTS  = 1 << ADDR_W,
    localparam int WIDE_OUTS = NUM_SECTIONS * SEC_OUTS
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 a_en_hi,
    input  logic                 a_en_lo_n,
    input  logic                 b_en_lo_n0,
    input  logic                 b_en_lo_n1,
    input  logic [1:0]           mode,
    input  logic [WIDE_OUTS-1:0] mask,
    output logic [SEC_OUTS-1:0]  a_out_n,
    output logic [SEC_OUTS-1:0]  b_out_n,
    output logic [WIDE_OUTS-1:0] wide_out_n,
    output logic                 wired_and
);

    dec_mode_e           mode_q;
    logic [NUM_SECTIONS-1:0] sec_e0;
    logic [NUM_SECTIONS-1:0] sec_e1;
    logic [NUM_SECTIONS-1:0] sec_en;
    logic [SEC_OUTS-1:0]     sec_out_n [NUM_SECTIONS];

    // Interpret the raw mode bits as the mode type.
    always_comb begin
        mode_q = dec_mode_e'(mode);
    end

    // Route the enable pins, applying the 3-to-8 strapping in wide mode.
    always_comb begin
        sec_e0[1] = a_en_hi;
        sec_e1[1] = a_en_lo_n;
        if (mode_q == MODE_WIDE) begin
            sec_e0[0] = a_en_hi;
            sec_e1[0] = a_en_lo_n;
        end else begin
            sec_e0[0] = b_en_lo_n0;
            sec_e1[0] = b_en_lo_n1;
        end
    end

    // Build one enable gate and one decoder per section.
    generate
        for (genvar s = 0; s < NUM_SECTIONS; s++) begin : g_sec
            dec_enable_gate #(
                .FIRST_ACT_HIGH(s == 1)
            ) u_gate (
                .e0 (sec_e0[s]),
                .e1 (sec_e1[s]),
                .en (sec_en[s])
            );

            dec_section #(
                .ADDR_W(ADDR_W)
            ) u_dec (
                .addr  (addr),
                .en    (sec_en[s]),
                .out_n (sec_out_n[s])
            );

            assign wide_out_n[s*SEC_OUTS +: SEC_OUTS] = sec_out_n[s];
        end
    endgenerate

    assign a_out_n = sec_out_n[1];
    assign b_out_n = sec_out_n[0];

    dec_wired_and #(
        .W(WIDE_OUTS)
    ) u_wired (
        .in_n   (wide_out_n),
        .sel    (mask),
        .active (mode_q == MODE_WIRED),
        .y      (wired_and)
    );

endmodule

// File: rtl/dual_gated_decoder_chk.sv
// Module: assertion checker bound to the dual gated decoder.
// Assumes the default 2-bit address, which gives 4-bit sections and an 8-bit wide bus.
module dual_gated_decoder_chk (
    input logic [1:0] addr,
    input logic       a_en_hi,
    input logic       a_en_lo_n,
    input logic       b_en_lo_n0,
    input logic       b_en_lo_n1,
    input logic [1:0] mode,
    input logic [7:0] mask,
    input logic [3:0] a_out_n,
    input logic [3:0] b_out_n,
    input logic [7:0] wide_out_n,
    input logic       wired_and
);

    // Check port relations every time any input or output changes.
    always_comb begin
        AST_A_ONE_LOW_MAX: assert ($countones(~a_out_n) <= 1); // R1
        AST_A_SELECT: assert (!(a_en_hi && !a_en_lo_n) || (a_out_n[addr] == 1'b0)); // R2
        AST_A_IDLE_HIGH: assert ((a_en_hi && !a_en_lo_n) || (a_out_n == 4'hF)); // R3
        AST_B_IDLE_HIGH: assert ((mode == 2'b01) || !(b_en_lo_n0 || b_en_lo_n1) || (b_out_n == 4'hF)); // R4
        AST_WIDE_SINGLE: assert ((mode != 2'b01) || a_en_lo_n || ($countones(~wide_out_n) == 1 && wide_out_n[{a_en_hi, addr}] == 1'b0)); // R7
        AST_WIDE_HALVES: assert (wide_out_n == {a_out_n, b_out_n}); // R8
        AST_WIRED_IDLE: assert ((mode == 2'b10) || wired_and); // R9
        AST_EMPTY_MASK: assert ((mask != 8'h00) || wired_and); // R10
    end

endmodule

bind dual_gated_decoder dual_gated_decoder_chk u_chk (
    .addr       (addr),
    .a_en_hi    (a_en_hi),
    .a_en_lo_n  (a_en_lo_n),
    .b_en_lo_n0 (b_en_lo_n0),
    .b_en_lo_n1 (b_en_lo_n1),
    .mode       (mode),
    .mask       (mask),
    .a_out_n    (a_out_n),
    .b_out_n    (b_out_n),
    .wide_out_n (wide_out_n),
    .wired_and  (wired_and)
);

// File: tb/tb_dual_gated_decoder.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the dual gated decoder, with one task per scenario.
module tb_dual_gated_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'b00;
    logic       a_en_hi = 1'b0;
    logic       a_en_lo_n = 1'b1;
    logic       b_en_lo_n0 = 1'b1;
    logic       b_en_lo_n1 = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [7:0] mask = 8'h00;
    logic [3:0] a_out_n;
    logic [3:0] b_out_n;
    logic [7:0] wide_out_n;
    logic       wired_and;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    dual_gated_decoder dut (
        .addr       (addr),
        .a_en_hi    (a_en_hi),
        .a_en_lo_n  (a_en_lo_n),
        .b_en_lo_n0 (b_en_lo_n0),
        .b_en_lo_n1 (b_en_lo_n1),
        .mode       (mode),
        .mask       (mask),
        .a_out_n    (a_out_n),
        .b_out_n    (b_out_n),
        .wide_out_n (wide_out_n),
        .wired_and  (wired_and)
    );

    // Compare one observed value with its expected value and record the result.
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: a 4-bit active-low one-cold code for the given index.
    function automatic logic [3:0] ref4(input logic en, input logic [1:0] idx);
        return en ? ~(4'b0001 << idx) : 4'hF;
    endfunction

    // Apply inputs away from the rising edge, then let them settle.
    task automatic drive(input logic [1:0] m, input logic [5:0] v, input logic [7:0] mk);
        @(negedge clk);
        mode = m; mask = mk;
        addr = v[1:0]; a_en_hi = v[2]; a_en_lo_n = v[3];
        b_en_lo_n0 = v[4]; b_en_lo_n1 = v[5];
        #1;
    endtask

    // Idle state: every enable inactive, so every output is high.
    task automatic t_idle();
        drive(2'b00, 6'b11_1_0_00, 8'h00);
        chk("R3 idle a_out_n", {4'h0, a_out_n}, 8'h0F);
        chk("R4 idle b_out_n", {4'h0, b_out_n}, 8'h0F);
        chk("R8 idle wide_out_n", wide_out_n, 8'hFF);
        chk("R9 idle wired_and", {7'h0, wired_and}, 8'h01);
    endtask

    // Dual-style sweep over all address and enable patterns for the given mode code.
    task automatic t_dual_sweep(input logic [1:0] m, input string tag);
        for (int v = 0; v < 64; v++) begin
            logic [5:0] vv;
            logic ea, eb;
            vv = 6'(v);
            ea = vv[2] & ~vv[3];
            eb = ~vv[4] & ~vv[5];
            drive(m, vv, 8'hFF);
            chk(ea ? {"R1 R2 ", tag} : {"R3 ", tag}, {4'h0, a_out_n}, {4'h0, ref4(ea, vv[1:0])});
            chk({"R4 ", tag}, {4'h0, b_out_n}, {4'h0, ref4(eb, vv[1:0])});
            chk({"R8 ", tag}, wide_out_n, {ref4(ea, vv[1:0]), ref4(eb, vv[1:0])});
            chk({"R9 not wired ", tag}, {7'h0, wired_and}, 8'h01);
        end
    endtask

    // Demultiplexing: data on each section A enable, watched on the addressed output.
    task automatic t_demux();
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 2; d++) begin
                drive(2'b00, {2'b11, 1'b0, 1'(d), 2'(a)}, 8'h00);
                chk("R5 true data", {7'h0, a_out_n[a]}, {7'h0, ~1'(d)});
                drive(2'b00, {2'b11, 1'(d), 1'b1, 2'(a)}, 8'h00);
                chk("R5 complement data", {7'h0, a_out_n[a]}, {7'h0, 1'(d)});
            end
        end
    endtask

    // Wide mode: 3-bit decode; the section B pins are varied to show they have no effect.
    task automatic t_wide_sweep();
        for (int v = 0; v < 64; v++) begin
            logic [5:0] vv;
            logic [7:0] exp;
            vv = 6'(v);
            exp = vv[3] ? 8'hFF : ~(8'h01 << {vv[2], vv[1:0]});
            drive(2'b01, vv, 8'h00);
            chk("R7 wide decode", wide_out_n, exp);
            chk("R8 wide upper is A", {4'h0, a_out_n}, {4'h0, exp[7:4]});
            chk("R8 wide lower is B", {4'h0, b_out_n}, {4'h0, exp[3:0]});
        end
    endtask

    // Wired mode: AND of the masked outputs for several masks.
    task automatic t_wired();
        logic [7:0] masks [6] = '{8'h01, 8'h80, 8'h0F, 8'hF0, 8'hA5, 8'hFF};
        foreach (masks[k]) begin
            for (int v = 0; v < 64; v++) begin
                logic [5:0] vv;
                logic [7:0] wexp;
                vv = 6'(v);
                wexp = {ref4(vv[2] & ~vv[3], vv[1:0]), ref4(~vv[4] & ~vv[5], vv[1:0])};
                drive(2'b10, vv, masks[k]);
                chk("R9 wired result", {7'h0, wired_and}, {7'h0, &(wexp | ~masks[k])});
                chk("R9 wired bus", wide_out_n, wexp);
            end
        end
    endtask

    // Empty mask in wired mode keeps the line high even when outputs are low.
    task automatic t_mask_empty();
        for (int v = 0; v < 64; v++) begin
            drive(2'b10, 6'(v), 8'h00);
            chk("R10 empty mask", {7'h0, wired_and}, 8'h01);
        end
    endtask

    // Print the summary line and end the run.
    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Main sequence of scenarios.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_dual_sweep(2'b00, "dual mode");
        t_dual_sweep(2'b11, "R6 spare code");
        t_demux();
        t_wide_sweep();
        t_wired();
        t_mask_empty();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule